// File: doc/BRIEF.md
# Bus-Target Cache Snoop Gate

This block stands between the target side of an external bus and the on-chip memory path. Each master read or write that reaches the target is accepted one at a time, and its address is compared against two programmable snoop windows. If snooping is on and either window matches, the block asks the CPU cache to clean the affected line. A read asks for a write-back (flush), and a write asks for write-back plus invalidate (purge). The memory access is held back until the cache acknowledges that request, and only then is it granted.

A 2-bit mode value of 00 turns snooping off, and every access then goes straight to memory. There are two cases the cache cannot serve. One is a window hit while the CPU is asleep. The other is a prefetch-marked transaction while snooping is on. Either case ends the transaction with a one-cycle error pulse and no memory grant.

Top module: `snoop_gate`

## Requirements
- R1: Each of the two windows holds a base, a mask and an enable bit. An address hits a window when that window is enabled and (addr & mask) == (base & mask). The snoop hit is the OR of the two window results.
- R2: When the mode value is 00, no transaction raises `cache_req`. A non-prefetch or prefetch access is then granted in the same cycle as a miss would be.
- R3: On a hit with snooping on, `cache_req` rises two cycles after the accepting edge. It stays high, with `mem_grant` low, until a cycle in which `cache_ack` is high. `mem_grant` is high in the following cycle.
- R4: While `cache_req` is high, `cache_purge` is 0 for a read (`txn_write`=0) and 1 for a write (`txn_write`=1).
- R5: A hit with snooping on while `cpu_sleep` is high produces `err` and `done` two cycles after the accepting edge, with no `cache_req` and no `mem_grant`.
- R6: A transaction with `txn_prefetch`=1 while the mode is non-zero is rejected with `err`, whether or not it hits. With mode 00 it is granted normally.
- R7: A miss (or mode 00) is accepted at edge k and has `mem_grant` and `done` high for exactly one cycle, namely the cycle after edge k+1. During that cycle `mem_write` and `mem_addr` show the accepted direction and address.
- R8: `txn_ready` is low from the accepting edge until the cycle after `done`, so only one transaction is in flight at a time.
- R9: A window whose enable bit is 0 never matches, whatever its base and mask.
- R10: `err` is a single-cycle pulse, always accompanied by `done` and never by `mem_grant`.
- R11: After reset `txn_ready` is 1, `cache_req`, `mem_grant`, `err` and `done` are 0, both windows are disabled and the mode is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one window's settings |
| cfg_idx | input | 1 | Selects window 0 or 1 for the write |
| cfg_en | input | 1 | Window enable value to store |
| cfg_base | input | AW | Window base value to store |
| cfg_mask | input | AW | Window mask value to store |
| mode_we | input | 1 | Write strobe for the snoop mode |
| mode_val | input | 2 | Snoop mode value; 00 turns snooping off |
| txn_valid | input | 1 | Incoming target transaction present |
| txn_write | input | 1 | 1 for write, 0 for read |
| txn_prefetch | input | 1 | Transaction is a prefetch |
| txn_addr | input | AW | Transaction address |
| txn_ready | output | 1 | Block is idle and accepts a transaction |
| cpu_sleep | input | 1 | CPU is in a sleep state |
| cache_req | output | 1 | Cache clean request |
| cache_purge | output | 1 | Request is a purge (1) or a flush (0) |
| cache_ack | input | 1 | Cache has finished the request |
| mem_grant | output | 1 | One-cycle memory access grant |
| mem_write | output | 1 | Direction of the granted access |
| mem_addr | output | AW | Address of the granted access |
| done | output | 1 | Transaction completed |
| err | output | 1 | Transaction rejected; no memory access |

## Verification
A corrupted window register or hit decision shows up at the ports two cycles after acceptance. It appears as a `cache_req` where a grant was due, or the reverse. A sequencer stuck waiting appears as `cache_req` that will not drop after `cache_ack`, and the bench's per-transaction cycle limit catches it within a few dozen cycles. A wrong sleep or prefetch decision shows up as a grant in the same cycle where `err` was expected.

// File: rtl/snoop_gate.sv
module snoop_gate #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_idx,
  input  logic          cfg_en,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_mask,
  input  logic          mode_we,
  input  logic [1:0]    mode_val,
  input  logic          txn_valid,
  input  logic          txn_write,
  input  logic          txn_prefetch,
  input  logic [AW-1:0] txn_addr,
  output logic          txn_ready,
  input  logic          cpu_sleep,
  output logic          cache_req,
  output logic          cache_purge,
  input  logic          cache_ack,
  output logic          mem_grant,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic          done,
  output logic          err
);
  typedef enum logic [2:0] {S_IDLE, S_COMPARE, S_WAIT, S_ACCESS, S_ERROR} state_t;
  state_t state_q;

  logic [AW-1:0] base_q [2];
  logic [AW-1:0] mask_q [2];
  logic [1:0]    en_q;
  logic [1:0]    mode_q;
  logic [AW-1:0] addr_q;
  logic          wr_q, pf_q;
  logic [1:0]    win_hit;
  logic          snoop_on, hit;

  for (genvar w = 0; w < 2; w++) begin : g_win
    assign win_hit[w] = en_q[w] && ((addr_q & mask_q[w]) == (base_q[w] & mask_q[w]));
  end

  assign snoop_on = (mode_q != 2'b00);
  assign hit      = snoop_on && (|win_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= 2'b00;
      for (int w = 0; w < 2; w++) begin
        base_q[w] <= '0;
        mask_q[w] <= '0;
      end
    end else begin
      if (cfg_we) begin
        base_q[cfg_idx] <= cfg_base;
        mask_q[cfg_idx] <= cfg_mask;
        en_q[cfg_idx]   <= cfg_en;
      end
      if (mode_we) mode_q <= mode_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      pf_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (txn_valid) begin
          addr_q  <= txn_addr;
          wr_q    <= txn_write;
          pf_q    <= txn_prefetch;
          state_q <= S_COMPARE;
        end
        S_COMPARE: begin
          if (snoop_on && pf_q)   state_q <= S_ERROR;
          else if (hit && cpu_sleep) state_q <= S_ERROR;
          else if (hit)           state_q <= S_WAIT;
          else                    state_q <= S_ACCESS;
        end
        S_WAIT:   if (cache_ack) state_q <= S_ACCESS;
        S_ACCESS: state_q <= S_IDLE;
        S_ERROR:  state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign txn_ready   = (state_q == S_IDLE);
  assign cache_req   = (state_q == S_WAIT);
  assign cache_purge = cache_req && wr_q;
  assign mem_grant   = (state_q == S_ACCESS);
  assign mem_write   = wr_q;
  assign mem_addr    = addr_q;
  assign err         = (state_q == S_ERROR);
  assign done        = mem_grant || err;
endmodule

module snoop_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic txn_valid,
  input logic txn_ready,
  input logic cache_req,
  input logic cache_ack,
  input logic mem_grant,
  input logic done,
  input logic err
);
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n) err |=> !err);
  a_r10_err_no_grant: assert property (@(posedge clk) disable iff (!rst_n) err |-> (done && !mem_grant));
  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_req && !cache_ack) |=> (cache_req && !mem_grant));
  a_r3_grant_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_req && cache_ack) |=> mem_grant);
  a_r7_no_early_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready) |=> (!mem_grant && !err && !txn_ready));
  a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n) done |=> txn_ready);
endmodule

bind snoop_gate snoop_gate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_ready(txn_ready),
  .cache_req(cache_req), .cache_ack(cache_ack), .mem_grant(mem_grant),
  .done(done), .err(err)
);

// File: tb/snoop_gate_tb.sv
module snoop_gate_tb_top;
  localparam int AW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_idx = 0, cfg_en = 0;
  logic [AW-1:0] cfg_base = '0, cfg_mask = '0;
  logic mode_we = 0;
  logic [1:0] mode_val = 0;
  logic txn_valid = 0, txn_write = 0, txn_prefetch = 0;
  logic [AW-1:0] txn_addr = '0;
  logic txn_ready, cpu_sleep = 0, cache_req, cache_purge, cache_ack = 0;
  logic mem_grant, mem_write, done, err;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  snoop_gate #(.AW(AW)) dut_i (.*);

  logic [AW-1:0] b0, m0, b1, m1;
  logic e0, e1;
  logic [1:0] mode_m;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_win(input bit idx, input bit en, input logic [AW-1:0] b, input logic [AW-1:0] m);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_en = en; cfg_base = b; cfg_mask = m;
    @(negedge clk);
    cfg_we = 0;
    if (idx == 0) begin e0 = en; b0 = b; m0 = m; end
    else begin e1 = en; b1 = b; m1 = m; end
  endtask

  task automatic set_mode(input logic [1:0] v);
    @(negedge clk);
    mode_we = 1; mode_val = v;
    @(negedge clk);
    mode_we = 0;
    mode_m = v;
  endtask

  task automatic run_txn(input logic [AW-1:0] a, input bit wr, input bit pf, input bit slp, input int dly);
    bit hit, on, exp_err, exp_req;
    int grant_n, err_n, req_first, reqcnt, errcnt, grantcnt;
    bit purge_ok, busy_ok, addr_ok;
    on = (mode_m != 2'b00);
    hit = on && ((e0 && ((a & m0) == (b0 & m0))) || (e1 && ((a & m1) == (b1 & m1))));
    exp_err = (on && pf) || (hit && slp);
    exp_req = hit && !exp_err;
    grant_n = 0; err_n = 0; req_first = 0; reqcnt = 0; errcnt = 0; grantcnt = 0;
    purge_ok = 1; busy_ok = 1; addr_ok = 1;
    @(negedge clk);
    txn_valid = 1; txn_addr = a; txn_write = wr; txn_prefetch = pf; cpu_sleep = slp;
    @(posedge clk);
    @(negedge clk);
    txn_valid = 0;
    for (int n = 1; n < 40; n++) begin
      if (n == 1 && txn_ready) busy_ok = 0;
      if (cache_req) begin
        reqcnt++;
        if (req_first == 0) req_first = n;
        if (cache_purge != wr) purge_ok = 0;
        cache_ack = (reqcnt > dly);
      end else cache_ack = 0;
      if (mem_grant) begin
        grantcnt++;
        if (grant_n == 0) grant_n = n;
        if (mem_addr != a || mem_write != wr) addr_ok = 0;
      end
      if (err) begin errcnt++; if (err_n == 0) err_n = n; end
      if (done) begin
        @(negedge clk);
        cache_ack = 0;
        chk(txn_ready, "R8 ready after done", txn_ready, 1);
        break;
      end
      @(negedge clk);
    end
    chk(busy_ok, "R8 busy after accept", busy_ok, 1);
    if (exp_err) begin
      chk(err_n == 2, "R5/R6 err cycle", err_n, 2);
      chk(errcnt == 1, "R10 err pulse length", errcnt, 1);
      chk(grantcnt == 0, "R10 no grant on err", grantcnt, 0);
      chk(reqcnt == 0, "R5 no cache_req on err", reqcnt, 0);
    end else if (exp_req) begin
      chk(req_first == 2, "R3 cache_req cycle", req_first, 2);
      chk(grant_n == 3 + dly, "R3 grant after ack", grant_n, 3 + dly);
      chk(purge_ok, "R4 flush/purge select", purge_ok, 1);
      chk(grantcnt == 1 && addr_ok, "R7 single grant with addr", grantcnt, 1);
    end else begin
      chk(reqcnt == 0, on ? "R1 miss has no cache_req" : "R2 mode 00 no cache_req", reqcnt, 0);
      chk(grant_n == 2, "R7 miss grant cycle", grant_n, 2);
      chk(grantcnt == 1 && addr_ok, "R7 single grant with addr", grantcnt, 1);
      chk(errcnt == 0, "R6 no err", errcnt, 0);
    end
  endtask

  initial begin
    logic [AW-1:0] addrs [8];
    addrs[0] = 16'h0100; addrs[1] = 16'h01FF; addrs[2] = 16'h0200; addrs[3] = 16'h3ABC;
    addrs[4] = 16'h4000; addrs[5] = 16'h3100; addrs[6] = 16'h0000; addrs[7] = 16'hF1F0;
    e0 = 0; e1 = 0; b0 = 0; b1 = 0; m0 = 0; m1 = 0; mode_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txn_ready === 1'b1, "R11 reset ready", txn_ready, 1);
    chk({cache_req, mem_grant, err, done} === 4'b0, "R11 reset outputs", {cache_req, mem_grant, err, done}, 0);
    set_mode(2'b01);
    run_txn(16'h0000, 0, 0, 0, 0);
    chk(1, "R9 disabled windows after reset", 0, 0);
    for (int v = 0; v < 4; v++) begin
      set_win(0, 1'b1, 16'h0100, 16'h0F00);
      set_win(1, v != 1, 16'h3000, 16'hF000);
      if (v == 2) set_win(0, 1'b0, 16'h0100, 16'h0F00);
      for (int md = 0; md < 2; md++) begin
        set_mode(md == 0 ? 2'b00 : (v == 3 ? 2'b11 : 2'b10));
        for (int i = 0; i < 8; i++)
          for (int k = 0; k < 8; k++)
            run_txn(addrs[i], k[0], k[1], k[2], (i + k) % 3);
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule